// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block collects 64 interrupt request lines and presents them to a processor as two outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each line has a one-byte control register. That register enables the line, selects level or edge sensing, and chooses where the line is routed. Edge events are held in sticky status bits until software clears them by writing ones. The block also reports, for each output, the index of the winning pending source. A rotating-priority mode can be switched on so that no single source holds the processor for long.

Software drives the block through a plain register port with byte-lane writes and word reads. Reads are combinational from the address. A read of an index register with `rd_en` high counts as the acknowledgement that advances the rotation. There is no streaming data path, so no valid/ready handshake is used. Every pin is a plain control or status signal.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00, both status words read 0, both index registers read 63, both priority controls read 0, and `irq_o` and `fiq_o` are low.
- R2: Control byte for source n lives at byte address 0x40+n (word 0x40+4*(n/4), lane n%4). Bit 3 is enable, bit 5 selects rising edge, bit 6 selects falling edge, both clear select active-high level, and bits 2:0 select the destination (0 = IRQ, 1 = FIQ, 2..7 drive neither output).
- R3: A rising edge on a source in rising mode sets its status bit even while the source is disabled; a disabled source never drives an output or an index.
- R4: A falling edge on a source in falling mode sets its status bit; a rising edge on that source does not.
- R5: A level-mode source shows in status its live input ANDed with its enable, and holds nothing once the input drops.
- R6: Writing 1 to a status bit (0x80 for sources 0..31, 0x84 for 32..63, bit n%32) clears a latched edge; writing 0 leaves it set.
- R7: `irq_o` goes high one clock after any enabled pending source routed to destination 0 exists, and low one clock after none does; `fiq_o` behaves the same for destination 1.
- R8: With rotation off, word 0x00 returns in bits 5:0 the lowest pending IRQ-routed index and word 0x04 the same for FIQ, and repeated acknowledged reads do not change it.
- R9: With nothing pending an index register reads 63; software tells a real source 63 apart by status bit 31 of word 0x84.
- R10: Priority control words are 0x20 (IRQ) and 0x24 (FIQ): bit 6 enables rotation and bits 5:0 hold the search start index, both writable and read back; with rotation on the search begins at the start index and wraps.
- R11: An acknowledged read (`rd_en` high) of an index register, with rotation on and a source pending, moves that output's start index to the reported index plus one, modulo 64.
- R12: A write changes only the control bytes whose `wr_be` lane bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read acknowledge; on an index word it drives rotation |
| addr | input | 8 | Byte address, word aligned (bits 1:0 ignored) |
| wr_be | input | 4 | Byte-lane enables for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_i | input | 64 | Interrupt source lines |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The hardest situation to reach is the rotation wrap. To get there, several sources must be pending at once, and the acknowledged reads must walk the start pointer past the highest one. The next winner then has to come from the low end of the vector. The stimulus holds three level sources (3, 20 and 50) active and turns rotation on with the start at zero. It then issues four acknowledged reads, expecting 3, 20, 50 and again 3. After that it reads the priority control to confirm the pointer landed at 4. Finally it loads the pointer directly to 21 and checks that 50 wins. A second hard case is a real source 63 against the idle value: both read 63, and the test separates them only through status bit 31 of word 0x84.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC = 64;
  localparam int IW   = $clog2(NSRC);
  localparam int DW   = 32;
  localparam int AW   = 8;
  localparam int CW   = 8;
  localparam int NLANE = DW / 8;

  localparam int BIT_EN   = 3;
  localparam int BIT_RISE = 5;
  localparam int BIT_FALL = 6;
  localparam int BIT_ROT  = 6;
  localparam int DEST_W   = 3;

  typedef enum logic [DEST_W-1:0] {
    DEST_IRQ = 3'd0,
    DEST_FIQ = 3'd1,
    DEST_X2  = 3'd2,
    DEST_X3  = 3'd3,
    DEST_X4  = 3'd4,
    DEST_X5  = 3'd5,
    DEST_X6  = 3'd6,
    DEST_X7  = 3'd7
  } dest_e;

  // word addresses (byte address >> 2)
  localparam logic [5:0] W_IRQ_IDX = 6'h00;
  localparam logic [5:0] W_FIQ_IDX = 6'h01;
  localparam logic [5:0] W_IRQ_CFG = 6'h08;
  localparam logic [5:0] W_FIQ_CFG = 6'h09;
  localparam logic [5:0] W_STAT_LO = 6'h20;
  localparam logic [5:0] W_STAT_HI = 6'h21;
  localparam logic [1:0] CTRL_REGION = 2'b01;
endpackage

// File: rtl/vic_src_slice.sv
module vic_src_slice
  import vic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_i,
  input  logic          ctrl_we,
  input  logic [CW-1:0] ctrl_wd,
  input  logic          clr_i,
  output logic [CW-1:0] ctrl_o,
  output logic          stat_o,
  output logic          lat_o,
  output logic          edge_o,
  output logic          act_irq_o,
  output logic          act_fiq_o
);
  logic [CW-1:0] ctrl_q;
  logic          prev_q;
  logic          lat_q;
  logic          edge_mode, rise, fall, ev, en, pend;
  dest_e         dest;

  assign en        = ctrl_q[BIT_EN];
  assign edge_mode = ctrl_q[BIT_RISE] | ctrl_q[BIT_FALL];
  assign rise      = src_i & ~prev_q;
  assign fall      = ~src_i & prev_q;
  assign ev        = (ctrl_q[BIT_RISE] & rise) | (ctrl_q[BIT_FALL] & fall);
  assign dest      = dest_e'(ctrl_q[DEST_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (ctrl_we) ctrl_q <= ctrl_wd;
      if (!edge_mode)  lat_q <= 1'b0;
      else if (ev)     lat_q <= 1'b1;
      else if (clr_i)  lat_q <= 1'b0;
    end
  end

  assign stat_o    = edge_mode ? lat_q : (src_i & en);
  assign pend      = stat_o & en;
  assign act_irq_o = pend && (dest == DEST_IRQ);
  assign act_fiq_o = pend && (dest == DEST_FIQ);
  assign ctrl_o    = ctrl_q;
  assign lat_o     = lat_q;
  assign edge_o    = edge_mode;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          cfg_we,
  input  logic [IW:0]   cfg_wd,
  input  logic          ack_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [IW:0]   cfg_o
);
  localparam logic [IW-1:0] IDLE = IW'(N - 1);

  logic          rot_q;
  logic [IW-1:0] start_q;
  logic [N-1:0]  hi_req;
  logic [IW-1:0] pick_hi, pick_all;
  logic          have_hi;

  always_comb begin
    for (int i = 0; i < N; i++) hi_req[i] = req_i[i] && rot_q && (IW'(i) >= start_q);
  end

  always_comb begin
    pick_hi  = '0;
    pick_all = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hi_req[i]) pick_hi  = IW'(i);
      if (req_i[i])  pick_all = IW'(i);
    end
  end

  assign have_hi = |hi_req;
  assign any_o   = |req_i;
  assign idx_o   = !any_o ? IDLE : (have_hi ? pick_hi : pick_all);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q   <= 1'b0;
      start_q <= '0;
    end else if (cfg_we) begin
      rot_q   <= cfg_wd[IW];
      start_q <= cfg_wd[IW-1:0];
    end else if (ack_i && rot_q && any_o) begin
      start_q <= (idx_o == IDLE) ? '0 : idx_o + 1'b1;
    end
  end

  assign cfg_o = {rot_q, start_q};
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NLANE-1:0] wr_be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NSRC-1:0]  src_i,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [5:0]      word;
  logic [CW-1:0]   ctrl_all [NSRC];
  logic [NSRC-1:0] stat, lat, edge_m, act_irq, act_fiq, clr;
  logic            irq_any, fiq_any;
  logic [IW-1:0]   irq_idx, fiq_idx;
  logic [IW:0]     irq_cfg, fiq_cfg;
  logic            irq_rot;
  logic [IW-1:0]   irq_start;

  assign word = addr[AW-1:2];

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam int LANE = n % NLANE;
    localparam int SBIT = n % DW;
    localparam logic [5:0] SWORD = (n < DW) ? W_STAT_LO : W_STAT_HI;
    logic we_n;
    assign we_n = wr_en && (word[5:4] == CTRL_REGION) &&
                  (word[3:0] == 4'(n / NLANE)) && wr_be[LANE];
    assign clr[n] = wr_en && (word == SWORD) && wr_be[SBIT / 8] && wdata[SBIT];
    vic_src_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[n]),
      .ctrl_we   (we_n),
      .ctrl_wd   (wdata[8*LANE +: 8]),
      .clr_i     (clr[n]),
      .ctrl_o    (ctrl_all[n]),
      .stat_o    (stat[n]),
      .lat_o     (lat[n]),
      .edge_o    (edge_m[n]),
      .act_irq_o (act_irq[n]),
      .act_fiq_o (act_fiq[n])
    );
  end

  logic irq_cfg_we, fiq_cfg_we, irq_ack, fiq_ack;
  assign irq_cfg_we = wr_en && (word == W_IRQ_CFG) && wr_be[0];
  assign fiq_cfg_we = wr_en && (word == W_FIQ_CFG) && wr_be[0];
  assign irq_ack    = rd_en && (word == W_IRQ_IDX);
  assign fiq_ack    = rd_en && (word == W_FIQ_IDX);

  vic_prio_pick #(.N(NSRC), .IW(IW)) u_pick_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (act_irq),
    .cfg_we (irq_cfg_we),
    .cfg_wd (wdata[IW:0]),
    .ack_i  (irq_ack),
    .any_o  (irq_any),
    .idx_o  (irq_idx),
    .cfg_o  (irq_cfg)
  );

  vic_prio_pick #(.N(NSRC), .IW(IW)) u_pick_fiq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (act_fiq),
    .cfg_we (fiq_cfg_we),
    .cfg_wd (wdata[IW:0]),
    .ack_i  (fiq_ack),
    .any_o  (fiq_any),
    .idx_o  (fiq_idx),
    .cfg_o  (fiq_cfg)
  );

  assign irq_rot   = irq_cfg[IW];
  assign irq_start = irq_cfg[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_any;
      fiq_o <= fiq_any;
    end
  end

  always_comb begin
    rdata = '0;
    if (word[5:4] == CTRL_REGION) begin
      for (int l = 0; l < NLANE; l++)
        rdata[8*l +: 8] = ctrl_all[{word[3:0], 2'(l)}];
    end else begin
      case (word)
        W_IRQ_IDX: rdata = DW'(irq_idx);
        W_FIQ_IDX: rdata = DW'(fiq_idx);
        W_IRQ_CFG: rdata = DW'(irq_cfg);
        W_FIQ_CFG: rdata = DW'(fiq_cfg);
        W_STAT_LO: rdata = stat[DW-1:0];
        W_STAT_HI: rdata = stat[NSRC-1:DW];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            irq_any,
  input logic            fiq_any,
  input logic [IW-1:0]   irq_idx,
  input logic [NSRC-1:0] act_irq,
  input logic            irq_rot,
  input logic [IW-1:0]   irq_start,
  input logic            rd_en,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NSRC-1:0] lat,
  input logic [NSRC-1:0] edge_m,
  input logic [NSRC-1:0] clr
);
  // R7: outputs follow the pending summary one clock later
  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |=> irq_o);
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any |=> !irq_o);
  p_fiq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_any |=> fiq_o);

  // R8: reported index is a pending IRQ-routed source
  p_idx_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> act_irq[irq_idx]);

  // R9: idle reads 63
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any |-> (irq_idx == IW'(NSRC - 1)));

  // R6: latched edge on source 0 persists until a clearing write
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat[0] && edge_m[0] && !clr[0]) |=> lat[0]);

  // R11: acknowledged read advances the start pointer
  p_rotate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr[AW-1:2] == W_IRQ_IDX && irq_rot && irq_any)
      |=> irq_start == IW'($past(irq_idx) + 1'b1));
endmodule

bind irq_vector_ctrl vic_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_any   (irq_any),
  .fiq_any   (fiq_any),
  .irq_idx   (irq_idx),
  .act_irq   (act_irq),
  .irq_rot   (irq_rot),
  .irq_start (irq_start),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .addr      (addr),
  .lat       (lat),
  .edge_m    (edge_m),
  .clr       (clr)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src_i = '0;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_be(wr_be), .wdata(wdata), .rdata(rdata), .src_i(src_i),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    addr = a; wdata = d; wr_be = be; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic ack, output logic [31:0] d);
    addr = a; rd_en = ack;
    #2 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_ctrl(input int n, input logic [7:0] v);
    wr(8'h40 + 8'(n & ~3), 32'(v) << (8 * (n % 4)), 4'b0001 << (n % 4));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, 1'b0, d); chk("R1 irq idx", d, 32'd63);
    rd(8'h04, 1'b0, d); chk("R1 fiq idx", d, 32'd63);
    rd(8'h40, 1'b0, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h7C, 1'b0, d); chk("R1 ctrl hi", d, 32'h0);
    rd(8'h20, 1'b0, d); chk("R1 prio cfg", d, 32'h0);
    rd(8'h80, 1'b0, d); chk("R1 stat", d, 32'h0);
    chk("R1 outs", {30'b0, irq_o, fiq_o}, 32'h0);
  endtask

  task automatic t_masked_edge;
    logic [31:0] d;
    set_ctrl(5, 8'h20);
    rd(8'h44, 1'b0, d); chk("R2 ctrl readback", d, 32'h0000_2000);
    src_i[5] = 1'b1; tick(2);
    rd(8'h80, 1'b0, d); chk("R3 masked edge latched", d, 32'h20);
    chk("R3 masked no irq", {31'b0, irq_o}, 32'h0);
    rd(8'h00, 1'b0, d); chk("R3 masked idx", d, 32'd63);
    src_i[5] = 1'b0;
    set_ctrl(5, 8'h28); tick(1);
    chk("R7 irq high", {31'b0, irq_o}, 32'h1);
    rd(8'h00, 1'b0, d); chk("R8 idx 5", d, 32'd5);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(8'h80, 32'hFFFF_FFDF, 4'hF); tick(1);
    rd(8'h80, 1'b0, d); chk("R6 write zero keeps", d, 32'h20);
    wr(8'h80, 32'h20, 4'b0001); tick(1);
    rd(8'h80, 1'b0, d); chk("R6 write one clears", d, 32'h0);
    chk("R7 irq low", {31'b0, irq_o}, 32'h0);
    set_ctrl(5, 8'h00);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    set_ctrl(40, 8'h48);
    src_i[40] = 1'b1; tick(2);
    rd(8'h84, 1'b0, d); chk("R4 rise ignored", d, 32'h0);
    src_i[40] = 1'b0; tick(2);
    rd(8'h84, 1'b0, d); chk("R4 fall latched", d, 32'h100);
    rd(8'h00, 1'b0, d); chk("R4 idx 40", d, 32'd40);
    wr(8'h84, 32'h100, 4'b0010); tick(1);
    rd(8'h84, 1'b0, d); chk("R6 hi clear", d, 32'h0);
    set_ctrl(40, 8'h00);
  endtask

  task automatic t_level;
    logic [31:0] d;
    set_ctrl(10, 8'h00);
    src_i[10] = 1'b1; tick(1);
    rd(8'h80, 1'b0, d); chk("R5 disabled level", d, 32'h0);
    set_ctrl(10, 8'h08);
    rd(8'h80, 1'b0, d); chk("R5 level live", d, 32'h400);
    rd(8'h00, 1'b0, d); chk("R5 idx 10", d, 32'd10);
    src_i[10] = 1'b0; tick(1);
    rd(8'h80, 1'b0, d); chk("R5 level drop", d, 32'h0);
    set_ctrl(10, 8'h00);
  endtask

  task automatic t_route;
    logic [31:0] d;
    set_ctrl(12, 8'h09);
    src_i[12] = 1'b1; tick(2);
    chk("R7 fiq routed", {30'b0, irq_o, fiq_o}, 32'h1);
    rd(8'h04, 1'b0, d); chk("R8 fiq idx", d, 32'd12);
    rd(8'h00, 1'b0, d); chk("R8 irq idle", d, 32'd63);
    set_ctrl(12, 8'h0B); tick(2);
    chk("R2 dest 3 silent", {30'b0, irq_o, fiq_o}, 32'h0);
    src_i[12] = 1'b0;
    set_ctrl(12, 8'h00);
  endtask

  task automatic t_idle63;
    logic [31:0] d;
    rd(8'h84, 1'b0, d); chk("R9 idle stat", d, 32'h0);
    set_ctrl(63, 8'h08);
    src_i[63] = 1'b1; tick(1);
    rd(8'h00, 1'b0, d); chk("R9 real 63 idx", d, 32'd63);
    rd(8'h84, 1'b0, d); chk("R9 real 63 stat", d, 32'h8000_0000);
    src_i[63] = 1'b0;
    set_ctrl(63, 8'h00);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    set_ctrl(3, 8'h08); set_ctrl(20, 8'h08); set_ctrl(50, 8'h08);
    src_i[3] = 1'b1; src_i[20] = 1'b1; src_i[50] = 1'b1; tick(1);
    rd(8'h00, 1'b1, d); chk("R8 fixed first", d, 32'd3);
    rd(8'h00, 1'b1, d); chk("R8 fixed repeat", d, 32'd3);
  endtask

  task automatic t_rotate;
    logic [31:0] d;
    wr(8'h20, 32'h40, 4'b0001);
    rd(8'h20, 1'b0, d); chk("R10 cfg readback", d, 32'h40);
    rd(8'h00, 1'b1, d); chk("R11 rot 1", d, 32'd3);
    rd(8'h00, 1'b1, d); chk("R11 rot 2", d, 32'd20);
    rd(8'h00, 1'b1, d); chk("R11 rot 3", d, 32'd50);
    rd(8'h00, 1'b1, d); chk("R11 rot wrap", d, 32'd3);
    rd(8'h20, 1'b0, d); chk("R11 start after", d, 32'h44);
    wr(8'h20, 32'h55, 4'b0001);
    rd(8'h00, 1'b0, d); chk("R10 start 21", d, 32'd50);
    rd(8'h20, 1'b0, d); chk("R10 cfg 21", d, 32'h55);
    src_i = '0;
    set_ctrl(3, 8'h00); set_ctrl(20, 8'h00); set_ctrl(50, 8'h00);
    wr(8'h20, 32'h0, 4'b0001);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr(8'h40, 32'h0808_0808, 4'b0010);
    rd(8'h40, 1'b0, d); chk("R12 lane write", d, 32'h0000_0800);
    wr(8'h40, 32'h0, 4'hF);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_masked_edge();
    t_clear();
    t_falling();
    t_level();
    t_route();
    t_idle63();
    t_fixed();
    t_rotate();
    t_lanes();
    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule